// File: doc/BRIEF.md
# Two-Wire Register Slave for a 10-Bit DAC

This block is the digital side of a voltage-output converter that a host programs over a two-wire serial bus. The block only ever acts as a slave. SCL and SDA are oversampled with a fast system clock, and the block recognises START, STOP and repeated START conditions. It answers one fixed 7-bit address. A command byte written after the address acts as a pointer into a two-entry register map: a 10-bit converter code and an 8-bit control byte whose bit 0 requests standby.

The host can use write-byte, write-word, read-byte, read-word and receive-byte transfers. A receive-byte transfer reuses the pointer left by the last command. The converter code is carried in two bytes, high end first. It changes as one unit when the second byte is acknowledged, so the analog side never sees half of a new code. SDA is open-drain: the block only ever pulls the line low through an output enable.

Top module: `smb_dac_port`

## Requirements
- R1: Only the address 7'b1001000 in bits 7:1 of the first byte after a START is acknowledged, with SDA low on the ninth clock. For any other address the block drives nothing, not even read data, until the next START or STOP.
- R2: Command 0x00 selects the code register. The first data byte written holds code bits 9:2. Bits 7:6 of the second byte hold code bits 1:0, and its bits 5:0 are ignored. `dac_code` changes only when the second byte is acknowledged.
- R3: Command 0x01 selects the control register. A written byte sets `standby` to its bit 0. Bits 7:1 are ignored.
- R4: A read with command 0x00 returns code bits 9:2 in the first byte, then a second byte holding code bits 1:0 in bits 7:6 with zeros below.
- R5: A read with command 0x01 returns 0x00 or 0x01, following `standby`. The reserved bits 7:1 always read 0.
- R6: A receive-byte transfer (a read address straight after START) returns the register chosen by the most recent command byte.
- R7: A command code other than 0x00 or 0x01 is acknowledged. Data written under it is acknowledged and discarded, and reads under it return 0x00.
- R8: A STOP or START at any point ends the current transfer. A code write cut off after its first data byte leaves `dac_code` unchanged. A repeated START goes back to the address phase, keeping the pointer.
- R9: After reset, `dac_code` is 0, `standby` is 0, `sda_oe` is 0 and the pointer selects the code register.
- R10: `sda_oe` changes only while SCL is low, and it is 0 whenever the block is idle or not addressed.
- R11: While `standby` is 1, the bus keeps working, and code writes still update `dac_code`.
- R12: When the master does not acknowledge a byte the block sent, the block releases SDA and sends nothing more until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dac_code | output | 10 | Code applied to the converter |
| standby | output | 1 | Standby request to the analog side |

## Verification
The hardest situation to reach is a transfer cut short in the middle of a register write, where the staging byte has been loaded but the code has not yet been committed. The stimulus reaches it with a master model that can stop after any byte: it sends the address, the command and one data byte, then issues a STOP or a repeated START. A read that follows shows the old code, and the pointer survives the repeated START. A second hard case is a non-matching address followed by more clocked bytes. The bench watches that `sda_oe` stays low through all of them, including an attempt to read.

// File: rtl/smbdac_pkg.sv
`timescale 1ns/1ps
package smbdac_pkg;

  localparam logic [6:0] DEF_SLV_ADDR = 7'b1001000;
  localparam logic [7:0] PTR_CODE     = 8'h00;
  localparam logic [7:0] PTR_CTRL     = 8'h01;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_CMD,
    LK_WR,
    LK_TX,
    LK_SKIP
  } link_st_e;

endpackage

// File: rtl/smb_pin_sync.sv
`timescale 1ns/1ps
module smb_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  // one extra flop beyond the synchronizer keeps the previous sample
  localparam int W = STAGES + 1;

  logic [W-1:0] scl_q, sda_q, scl_d, sda_d;
  logic         scl_p, sda_p;

  always_comb begin
    scl_d = {scl_q[W-2:0], scl_i};
    sda_d = {sda_q[W-2:0], sda_i};
  end

  // idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_s = scl_q[W-2];
  assign sda_s = sda_q[W-2];
  assign scl_p = scl_q[W-1];
  assign sda_p = sda_q[W-1];

  assign scl_rise  =  scl_s & ~scl_p;
  assign scl_fall  = ~scl_s &  scl_p;
  assign start_evt =  scl_s &  scl_p &  sda_p & ~sda_s;
  assign stop_evt  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/smb_link.sv
`timescale 1ns/1ps
module smb_link
  import smbdac_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = DEF_SLV_ADDR
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic [7:0] rd_byte,
  output logic [1:0] rd_idx,
  output logic [7:0] ptr,
  output logic [1:0] wr_idx,
  output logic [7:0] wr_byte,
  output logic       wr_stb,
  output logic       sda_oe
);

  localparam logic [3:0] NB_ACK_OPEN = 4'd8;
  localparam logic [3:0] NB_ACK_DONE = 4'd9;
  localparam logic [1:0] IDX_MAX     = 2'd2;

  link_st_e   st_q, st_d;
  logic [3:0] nbit_q, nbit_d;
  logic [7:0] rx_q, rx_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] ptr_q, ptr_d;
  logic [1:0] idx_q, idx_d;
  logic       mnack_q, mnack_d;
  logic       oe_q, oe_d;
  logic       addr_hit;
  logic [1:0] idx_inc;

  assign addr_hit = (rx_q[7:1] == SLV_ADDR);
  assign idx_inc  = (idx_q == IDX_MAX) ? idx_q : idx_q + 2'd1;
  // byte index the next transmitted byte will come from
  assign rd_idx   = (st_q == LK_TX) ? idx_inc : 2'd0;

  always_comb begin
    st_d    = st_q;
    nbit_d  = nbit_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    idx_d   = idx_q;
    mnack_d = mnack_q;
    oe_d    = oe_q;
    wr_stb  = 1'b0;

    if (stop_evt) begin
      st_d   = LK_IDLE;
      nbit_d = '0;
      oe_d   = 1'b0;
    end else if (start_evt) begin
      st_d   = LK_ADDR;
      nbit_d = '0;
      oe_d   = 1'b0;
    end else if (st_q != LK_IDLE && st_q != LK_SKIP) begin
      if (scl_rise) begin
        if (nbit_q < NB_ACK_OPEN) begin
          rx_d   = {rx_q[6:0], sda_s};
          nbit_d = nbit_q + 4'd1;
        end else if (nbit_q == NB_ACK_OPEN) begin
          mnack_d = sda_s;
          nbit_d  = NB_ACK_DONE;
        end
      end else if (scl_fall) begin
        if (nbit_q == NB_ACK_OPEN) begin
          // ninth clock slot opens
          unique case (st_q)
            LK_ADDR: oe_d = addr_hit;
            LK_CMD:  oe_d = 1'b1;
            LK_WR: begin
              oe_d   = 1'b1;
              wr_stb = 1'b1;
            end
            default: oe_d = 1'b0;
          endcase
        end else if (nbit_q == NB_ACK_DONE) begin
          // ninth clock slot closes
          nbit_d = '0;
          oe_d   = 1'b0;
          unique case (st_q)
            LK_ADDR: begin
              if (!addr_hit) begin
                st_d = LK_SKIP;
              end else if (rx_q[0]) begin
                st_d  = LK_TX;
                idx_d = 2'd0;
                tx_d  = rd_byte;
                oe_d  = ~rd_byte[7];
              end else begin
                st_d = LK_CMD;
              end
            end
            LK_CMD: begin
              ptr_d = rx_q;
              idx_d = 2'd0;
              st_d  = LK_WR;
            end
            LK_WR: idx_d = idx_inc;
            LK_TX: begin
              if (!mnack_q) begin
                idx_d = idx_inc;
                tx_d  = rd_byte;
                oe_d  = ~rd_byte[7];
              end else begin
                st_d = LK_SKIP;
              end
            end
            default: st_d = st_q;
          endcase
        end else if (st_q == LK_TX) begin
          tx_d = {tx_q[6:0], 1'b0};
          oe_d = ~tx_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LK_IDLE;
      nbit_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= PTR_CODE;
      idx_q   <= '0;
      mnack_q <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      nbit_q  <= nbit_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
      mnack_q <= mnack_d;
      oe_q    <= oe_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_idx  = idx_q;
  assign wr_byte = rx_q;
  assign sda_oe  = oe_q;

  // R1: an acknowledge in the address phase implies the received address matched
  p_addr_ack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_ADDR && nbit_q == NB_ACK_OPEN && oe_q) |-> (rx_q[7:1] == SLV_ADDR));

  // R10: the line is released whenever the port is idle or not addressed
  p_quiet_when_unselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LK_IDLE || st_q == LK_SKIP) |-> !oe_q);

  // R10: the enable only moves while the synchronized clock line is low
  p_oe_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);

  // R12: after a master NACK on a sent byte nothing more is driven
  p_nack_releases_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == LK_TX && st_q == LK_SKIP) |-> !oe_q);

endmodule

// File: rtl/dac_regs.sv
`timescale 1ns/1ps
module dac_regs
  import smbdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [7:0]        ptr,
  input  logic [1:0]        wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic [1:0]        rd_idx,
  output logic [7:0]        rd_byte,
  output logic [CODE_W-1:0] dac_code,
  output logic              standby
);

  // high byte carries the top eight code bits, the rest ride at the top of byte two
  localparam int LO_W  = CODE_W - 8;
  localparam int PAD_W = 8 - LO_W;

  logic [7:0]        stage_q, stage_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              stby_q, stby_d;
  logic              sel_code, sel_ctrl;

  assign sel_code = (ptr == PTR_CODE);
  assign sel_ctrl = (ptr == PTR_CTRL);

  always_comb begin
    stage_d = stage_q;
    code_d  = code_q;
    stby_d  = stby_q;
    if (wr_stb) begin
      if (sel_code && wr_idx == 2'd0) stage_d = wr_byte;
      if (sel_code && wr_idx == 2'd1) code_d  = {stage_q, wr_byte[7:PAD_W]};
      if (sel_ctrl && wr_idx == 2'd0) stby_d  = wr_byte[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      code_q  <= '0;
      stby_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      code_q  <= code_d;
      stby_q  <= stby_d;
    end
  end

  always_comb begin
    rd_byte = 8'h00;
    if (sel_code && rd_idx == 2'd0) rd_byte = code_q[CODE_W-1:LO_W];
    if (sel_code && rd_idx == 2'd1) rd_byte = {code_q[LO_W-1:0], {PAD_W{1'b0}}};
    if (sel_ctrl && rd_idx == 2'd0) rd_byte = {7'd0, stby_q};
  end

  assign dac_code = code_q;
  assign standby  = stby_q;

  // R2: the code only moves on a strobe for the second byte of a code write
  p_code_atomic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(wr_stb && ptr == PTR_CODE && wr_idx == 2'd1));

  // R7: an unknown pointer leaves both registers alone
  p_unknown_ptr_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sel_code && !sel_ctrl) |-> ($stable(code_q) && $stable(stby_q)));

endmodule

// File: rtl/smb_dac_port.sv
`timescale 1ns/1ps
module smb_dac_port
  import smbdac_pkg::*;
#(
  parameter int         CODE_W      = 10,
  parameter logic [6:0] SLV_ADDR    = DEF_SLV_ADDR,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [CODE_W-1:0] dac_code,
  output logic              standby
);

  logic [1:0] rst_sh;
  logic       rst_ln;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0] rd_byte, ptr, wr_byte;
  logic [1:0] rd_idx, wr_idx;
  logic       wr_stb;

  // reset asserts at once and leaves in step with the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_ln = rst_sh[1];

  smb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_ln),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  smb_link #(.SLV_ADDR(SLV_ADDR)) u_link (
    .clk       (clk),
    .rst_n     (rst_ln),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .rd_byte   (rd_byte),
    .rd_idx    (rd_idx),
    .ptr       (ptr),
    .wr_idx    (wr_idx),
    .wr_byte   (wr_byte),
    .wr_stb    (wr_stb),
    .sda_oe    (sda_oe)
  );

  dac_regs #(.CODE_W(CODE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_ln),
    .wr_stb   (wr_stb),
    .ptr      (ptr),
    .wr_idx   (wr_idx),
    .wr_byte  (wr_byte),
    .rd_idx   (rd_idx),
    .rd_byte  (rd_byte),
    .dac_code (dac_code),
    .standby  (standby)
  );

endmodule

// File: tb/test_smb_dac_port.sv
`timescale 1ns/1ps
module test_smb_dac_port;

  localparam realtime QP    = 100ns;
  localparam logic [7:0] AW = 8'h90;
  localparam logic [7:0] AR = 8'h91;

  localparam logic [2:0] K_WW = 3'd0;
  localparam logic [2:0] K_WB = 3'd1;
  localparam logic [2:0] K_RW = 3'd2;
  localparam logic [2:0] K_RB = 3'd3;
  localparam logic [2:0] K_RX = 3'd4;

  typedef struct packed {
    logic [2:0] kind;
    logic [7:0] cmd;
    logic [7:0] d0;
    logic [7:0] d1;
    logic [7:0] e0;
    logic [7:0] e1;
    logic [9:0] code;
    logic       stby;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{K_WW, 8'h00, 8'hA5, 8'hC0, 8'h00, 8'h00, 10'h297, 1'b0},
    '{K_RW, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hC0, 10'h297, 1'b0},
    '{K_WB, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h00, 10'h297, 1'b1},
    '{K_RB, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 10'h297, 1'b1},
    '{K_RX, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 10'h297, 1'b1},
    '{K_WB, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 10'h297, 1'b0},
    '{K_RB, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 10'h297, 1'b0},
    '{K_WW, 8'h00, 8'h00, 8'h7F, 8'h00, 8'h00, 10'h001, 1'b0},
    '{K_RW, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 10'h001, 1'b0},
    '{K_RX, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 10'h001, 1'b0},
    '{K_WW, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 10'h3FF, 1'b0},
    '{K_RW, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hC0, 10'h3FF, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [9:0] dac_code;
  logic       standby;
  logic       sda_bus;
  int         n_chk = 0;
  int         n_err = 0;
  int         r10_viol = 0;
  logic       prev_oe = 1'b0;
  logic       done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5ns clk = ~clk;

  smb_dac_port i_smb_dac_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .dac_code (dac_code),
    .standby  (standby)
  );

  // R10 monitor: the slave may only move its enable while SCL is low
  always @(posedge clk) begin
    if (sda_oe !== prev_oe && scl_m) r10_viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #QP;
    scl_m = 1'b1; #QP;
    sda_m = 1'b0; #QP;
    scl_m = 1'b0; #QP;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #QP;
    scl_m = 1'b1; #QP;
    sda_m = 1'b1; #QP;
  endtask

  task automatic send(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #QP;
      scl_m = 1'b1; #(2*QP);
      scl_m = 1'b0; #QP;
    end
    sda_m = 1'b1; #QP;
    scl_m = 1'b1; #QP;
    nack = sda_bus; #QP;
    scl_m = 1'b0; #QP;
  endtask

  task automatic recv(output logic [7:0] b, input logic give_nack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #QP;
      scl_m = 1'b1; #QP;
      b[i] = sda_bus; #QP;
      scl_m = 1'b0; #QP;
    end
    sda_m = give_nack; #QP;
    scl_m = 1'b1; #(2*QP);
    scl_m = 1'b0; #QP;
  endtask

  task automatic wr_word(input logic [7:0] cmd, d0, d1, output logic anyn);
    logic n0, n1, n2, n3;
    bus_start();
    send(AW, n0); send(cmd, n1); send(d0, n2); send(d1, n3);
    bus_stop();
    anyn = n0 | n1 | n2 | n3;
  endtask

  task automatic wr_byte(input logic [7:0] cmd, d0, output logic anyn);
    logic n0, n1, n2;
    bus_start();
    send(AW, n0); send(cmd, n1); send(d0, n2);
    bus_stop();
    anyn = n0 | n1 | n2;
  endtask

  task automatic rd_bytes(input logic [7:0] cmd, input logic two,
                          output logic [7:0] r0, r1, output logic anyn);
    logic n0, n1, n2;
    bus_start();
    send(AW, n0); send(cmd, n1);
    bus_start();
    send(AR, n2);
    r1 = 8'h00;
    if (two) begin
      recv(r0, 1'b0); recv(r1, 1'b1);
    end else begin
      recv(r0, 1'b1);
    end
    bus_stop();
    anyn = n0 | n1 | n2;
  endtask

  task automatic rx_only(output logic [7:0] r0, output logic anyn);
    bus_start();
    send(AR, anyn);
    recv(r0, 1'b1);
    bus_stop();
  endtask

  initial begin
    #(950us);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1;
    logic       nk, n0, n1, n2;

    rst_n = 1'b0;
    #(200ns);
    // R9: reset state
    chk("R9 code after reset", 16'(dac_code), 16'h0);
    chk("R9 standby after reset", 16'(standby), 16'h0);
    chk("R9 sda_oe after reset", 16'(sda_oe), 16'h0);
    rst_n = 1'b1;
    #(200ns);
    rx_only(r0, nk);
    chk("R9 pointer after reset reads code", 16'(r0), 16'h00);
    chk("R9 address ack", 16'(nk), 16'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VEC[i];
      unique case (v.kind)
        K_WW: begin
          wr_word(v.cmd, v.d0, v.d1, nk);
          chk("R2 write-word acks", 16'(nk), 16'h0);
          chk("R2 code after write-word", 16'(dac_code), 16'(v.code));
        end
        K_WB: begin
          wr_byte(v.cmd, v.d0, nk);
          chk("R3 write-byte acks", 16'(nk), 16'h0);
          chk("R3 standby after write", 16'(standby), 16'(v.stby));
        end
        K_RW: begin
          rd_bytes(v.cmd, 1'b1, r0, r1, nk);
          chk("R4 read-word acks", 16'(nk), 16'h0);
          chk("R4 first byte", 16'(r0), 16'(v.e0));
          chk("R4 second byte", 16'(r1), 16'(v.e1));
        end
        K_RB: begin
          rd_bytes(v.cmd, 1'b0, r0, r1, nk);
          chk("R5 read-byte acks", 16'(nk), 16'h0);
          chk("R5 control readback", 16'(r0), 16'(v.e0));
        end
        default: begin
          rx_only(r0, nk);
          chk("R6 receive-byte ack", 16'(nk), 16'h0);
          chk("R6 receive-byte data", 16'(r0), 16'(v.e0));
        end
      endcase
      chk("R2 code stable across vector", 16'(dac_code), 16'(v.code));
      chk("R3 standby across vector", 16'(standby), 16'(v.stby));
    end

    // R1: foreign address, write then read
    bus_start();
    send(8'h92, n0); send(8'h00, n1); send(8'h55, n2);
    bus_stop();
    chk("R1 foreign address not acked", 16'(n0), 16'h1);
    chk("R1 later bytes not acked", 16'(n1 & n2), 16'h1);
    chk("R1 code untouched", 16'(dac_code), 16'h3FF);
    bus_start();
    send(8'h93, n0);
    recv(r0, 1'b1);
    bus_stop();
    chk("R1 foreign read not acked", 16'(n0), 16'h1);
    chk("R1 foreign read drives nothing", 16'(r0), 16'hFF);

    // R8: STOP after the first code byte
    bus_start();
    send(AW, n0); send(8'h00, n1); send(8'h12, n2);
    bus_stop();
    chk("R8 partial write acks", 16'(n0 | n1 | n2), 16'h0);
    chk("R8 code kept after STOP", 16'(dac_code), 16'h3FF);

    // R8: repeated START after the first code byte, then read
    bus_start();
    send(AW, n0); send(8'h00, n1); send(8'h34, n2);
    bus_start();
    send(AR, nk);
    recv(r0, 1'b0); recv(r1, 1'b1);
    bus_stop();
    chk("R8 read after repeated START acked", 16'(nk), 16'h0);
    chk("R8 high byte unchanged", 16'(r0), 16'hFF);
    chk("R8 low byte unchanged", 16'(r1), 16'hC0);
    chk("R8 code kept after repeated START", 16'(dac_code), 16'h3FF);

    // R12: master NACK on first sent byte releases SDA
    bus_start();
    send(AW, n0); send(8'h00, n1);
    bus_start();
    send(AR, n2);
    recv(r0, 1'b1);
    #QP;
    chk("R12 released after NACK", 16'(sda_oe), 16'h0);
    chk("R12 byte before NACK", 16'(r0), 16'hFF);
    scl_m = 1'b1; #QP;
    chk("R12 line high during extra clock", 16'(sda_bus), 16'h1);
    scl_m = 1'b0; #QP;
    bus_stop();

    // R7: unknown command
    wr_byte(8'h05, 8'hFF, nk);
    chk("R7 unknown command acked", 16'(nk), 16'h0);
    chk("R7 code untouched", 16'(dac_code), 16'h3FF);
    chk("R7 standby untouched", 16'(standby), 16'h0);
    rd_bytes(8'h05, 1'b1, r0, r1, nk);
    chk("R7 unknown read acks", 16'(nk), 16'h0);
    chk("R7 unknown read zero", 16'({r0, r1}), 16'h0000);

    // R11: code writes still land in standby
    wr_byte(8'h01, 8'h01, nk);
    wr_word(8'h00, 8'h12, 8'h80, nk);
    chk("R11 write acks in standby", 16'(nk), 16'h0);
    chk("R11 standby held", 16'(standby), 16'h1);
    chk("R11 code updated in standby", 16'(dac_code), 16'h04A);

    // R10: monitor tally
    chk("R10 enable moved with SCL high", 16'(r10_viol), 16'h0);

    // R9: second reset clears everything
    rst_n = 1'b0;
    #(100ns);
    chk("R9 code cleared by reset", 16'(dac_code), 16'h0);
    chk("R9 standby cleared by reset", 16'(standby), 16'h0);
    rst_n = 1'b1;
    #(200ns);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule